// File: doc/BRIEF.md
# UART Transmitter with Holding-Empty and Line-Empty Interrupts

This block is the transmit half of a UART. Characters written by the CPU go into a 16-entry queue. A shifter takes them one at a time and sends each as a serial frame on `txd`. The interrupt unit raises two sources:

- **Holding-empty** fires when the queue drains. Its timing depends on how full the queue got. If the queue held two or more characters at once since the previous drain, the source becomes pending right away. If it did not, the source is held back by one character time minus the stop bits. This lets software that writes a single character learn, through this source, when that character's data and parity bits have gone out.
- **Line-empty** fires when the final stop bit has left the line and nothing is queued. Software can use it to switch a half-duplex driver off or to power the port down, without polling.

The CPU sees the highest-priority enabled source through a 4-bit identification code. Reading that code acknowledges only the source it reported.

The write port is a valid/ready channel. `wr_ready` is high whenever the queue has room. A beat offered while `wr_ready` is low is discarded rather than held, and the sticky `overflow` flag records the loss. All other pins are plain level or pulse signals. Baud timing comes from outside as a one-cycle `baud_tick` strobe, one per bit time.

Top module: `uart_tx_irq`

## Requirements
- R1: `txd` idles at 1. Each frame is sent in this order: a 0 start bit, then 5 to 8 data bits LSB first (`cfg_wlen` 0,1,2,3 selects 5,6,7,8 bits), then a parity bit when `cfg_par_en` is 1, then one stop bit (two when `cfg_stop2` is 1) at level 1. Parity makes the count of ones across data plus parity even when `cfg_par_odd` is 0, and odd when it is 1. Each `baud_tick` moves the line to the next bit.
- R2: Suppose the queue has not held two or more characters since the last drain. When it drains (a character is moved into the shifter and the queue is left empty), holding-empty becomes pending after 6 + `cfg_wlen` + `cfg_par_en` baud ticks. This count is the start, data and parity bits, measured from the load.
- R3: If the queue held two or more characters at once since the previous drain, holding-empty becomes pending on the same clock edge that empties the queue.
- R4: An accepted write clears both pending sources and cancels a running holding-empty delay.
- R5: A pulse on `iir_rd` clears only the source currently reported in `iir`. Any lower-priority source remains pending.
- R6: `iir` reads 4'b0001 when no enabled source is pending. It reads 4'b0010 for holding-empty (bits 3:1 = 001) and 4'b1110 for line-empty. Holding-empty outranks line-empty. A source counts only while its enable (`ien_thre`, `ien_temt`) is 1. `irq` is high exactly when `iir` differs from 4'b0001. Pending flags are kept while their enable is 0.
- R7: `thre` is 1 when the queue is empty. `temt` is 1 when the queue is empty and the shifter is idle. Line-empty becomes pending on the edge where the last stop bit completes and no character is waiting.
- R8: The queue holds 16 characters. `wr_ready` is 0 while it is full. A write offered while full is dropped and never sent, and it sets `overflow`, which stays 1 until reset.
- R9: After reset: `txd`=1, `thre`=1, `temt`=1, `wr_ready`=1, `overflow`=0, `irq`=0, `iir`=4'b0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Queue has room |
| wr_data | input | 8 | Character to send |
| iir_rd | input | 1 | One-cycle read strobe of the identification code |
| baud_tick | input | 1 | One-cycle strobe per bit time |
| cfg_wlen | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| ien_thre | input | 1 | Holding-empty source enable |
| ien_temt | input | 1 | Line-empty source enable |
| txd | output | 1 | Serial line |
| thre | output | 1 | Queue empty status |
| temt | output | 1 | Queue and shifter empty status |
| overflow | output | 1 | Sticky dropped-write flag |
| irq | output | 1 | Interrupt request |
| iir | output | 4 | Identification code |

## Verification
The assertions make three assumptions about the inputs:

- `baud_tick` and `iir_rd` are single-cycle pulses.
- The frame-format settings stay constant while a character is in flight or a holding-empty delay is running.
- A write beat is dropped, not retried, when `wr_ready` is low.

The bench respects each of these. It spaces ticks two clocks apart and uses one-clock pulses for both strobes. It changes the format only after the line is idle and both sources have been acknowledged. When it overfills the queue, it offers exactly one extra write and does not retry it.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 1 + DATA_W + 1 + 2;

  typedef enum logic [3:0] {
    IID_NONE = 4'b0001,
    IID_THRE = 4'b0010,
    IID_TEMT = 4'b1110
  } iid_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } fmt_t;

  // start + data + parity bit count
  function automatic logic [3:0] head_len(fmt_t f);
    return 4'd6 + {2'b00, f.wlen} + {3'b000, f.par_en};
  endfunction

  function automatic logic [3:0] frame_len(fmt_t f);
    return head_len(f) + 4'd1 + {3'b000, f.stop2};
  endfunction
endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       empty,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  fmt_t              fmt,
  output logic              busy,
  output logic              txd,
  output logic              done
);
  logic [FRAME_W-1:0] sh, frame;
  logic [3:0]         left;

  always_comb begin
    logic par;
    int   nd;
    nd    = 5 + int'(fmt.wlen);
    par   = fmt.par_odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nd) begin
        frame[1+i] = din[i];
        par        = par ^ din[i];
      end
    end
    if (fmt.par_en) frame[1+nd] = par;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sh   <= frame;
      left <= frame_len(fmt);
      busy <= 1'b1;
    end else if (busy && tick) begin
      sh   <= {1'b1, sh[FRAME_W-1:1]};
      left <= left - 4'd1;
      if (left == 4'd1) busy <= 1'b0;
    end
  end

  assign txd  = busy ? sh[0] : 1'b1;
  assign done = busy && tick && (left == 4'd1);
endmodule

// File: rtl/utx_irq_ctl.sv
module utx_irq_ctl
  import utx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_acc,
  input  logic       iir_rd,
  input  logic       ien_thre,
  input  logic       ien_temt,
  input  logic       drain_evt,
  input  logic       q_ge2,
  input  logic       line_done,
  input  logic [3:0] hold_len,
  output logic       irq,
  output logic [3:0] iir
);
  logic       thre_p, temt_p, multi, dly_run;
  logic [3:0] dly;
  iid_e       code;

  always_comb begin
    if (thre_p && ien_thre)      code = IID_THRE;
    else if (temt_p && ien_temt) code = IID_TEMT;
    else                         code = IID_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_p  <= 1'b0;
      temt_p  <= 1'b0;
      dly_run <= 1'b0;
      dly     <= '0;
    end else if (wr_acc) begin
      thre_p  <= 1'b0;
      temt_p  <= 1'b0;
      dly_run <= 1'b0;
    end else begin
      if (iir_rd) begin
        if (code == IID_THRE)      thre_p <= 1'b0;
        else if (code == IID_TEMT) temt_p <= 1'b0;
      end
      if (drain_evt) begin
        if (multi) thre_p <= 1'b1;
        else begin
          dly_run <= 1'b1;
          dly     <= hold_len;
        end
      end else if (dly_run && tick) begin
        if (dly == 4'd1) begin
          thre_p  <= 1'b1;
          dly_run <= 1'b0;
        end else begin
          dly <= dly - 4'd1;
        end
      end
      if (line_done) temt_p <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         multi <= 1'b0;
    else if (drain_evt) multi <= 1'b0;
    else if (q_ge2)     multi <= 1'b1;
  end

  assign iir = code;
  assign irq = (code != IID_NONE);
endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq
  import utx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              iir_rd,
  input  logic              baud_tick,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              ien_thre,
  input  logic              ien_temt,
  output logic              txd,
  output logic              thre,
  output logic              temt,
  output logic              overflow,
  output logic              irq,
  output logic [3:0]        iir
);
  localparam int CW = $clog2(DEPTH) + 1;

  fmt_t              fmt;
  logic              push, pop, q_empty, q_full, busy, done;
  logic [DATA_W-1:0] q_dout;
  logic [CW-1:0]     q_cnt;
  logic              drain_evt, line_done;

  assign fmt       = '{wlen: cfg_wlen, par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};
  assign wr_ready  = !q_full;
  assign push      = wr_valid && wr_ready;
  assign pop       = !busy && !q_empty;
  assign drain_evt = pop && (q_cnt == CW'(1)) && !push;
  assign line_done = done && q_empty && !push;

  utx_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(wr_data), .pop(pop),
    .dout(q_dout), .count(q_cnt), .empty(q_empty), .full(q_full)
  );

  utx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load(pop), .din(q_dout),
    .fmt(fmt), .busy(busy), .txd(txd), .done(done)
  );

  utx_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .wr_acc(push), .iir_rd(iir_rd),
    .ien_thre(ien_thre), .ien_temt(ien_temt), .drain_evt(drain_evt),
    .q_ge2(q_cnt >= CW'(2)), .line_done(line_done), .hold_len(head_len(fmt)),
    .irq(irq), .iir(iir)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     overflow <= 1'b0;
    else if (wr_valid && !wr_ready) overflow <= 1'b1;
  end

  assign thre = q_empty;
  assign temt = q_empty && !busy;
endmodule

// File: rtl/uart_tx_irq_chk.sv
module uart_tx_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       txd,
  input logic       thre,
  input logic       temt,
  input logic       overflow,
  input logic       irq,
  input logic [3:0] iir
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    temt |-> txd);

  a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !irq);

  a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (iir == 4'b0010 || iir == 4'b1110));

  a_r6_no_source: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (iir == 4'b0001));

  a_r7_temt_needs_thre: assert property (@(posedge clk) disable iff (!rst_n)
    temt |-> thre);

  a_r8_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> overflow);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r8_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    thre |-> wr_ready);
endmodule

bind uart_tx_irq uart_tx_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .txd(txd), .thre(thre), .temt(temt), .overflow(overflow), .irq(irq), .iir(iir)
);

// File: tb/sim_uart_tx_irq.sv
module sim_uart_tx_irq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_valid, wr_ready;
  logic [7:0] wr_data;
  logic       iir_rd, baud_tick;
  logic [1:0] cfg_wlen;
  logic       cfg_par_en, cfg_par_odd, cfg_stop2, ien_thre, ien_temt;
  logic       txd, thre, temt, overflow, irq;
  logic [3:0] iir;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  uart_tx_irq u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .iir_rd(iir_rd), .baud_tick(baud_tick),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .ien_thre(ien_thre), .ien_temt(ien_temt),
    .txd(txd), .thre(thre), .temt(temt), .overflow(overflow), .irq(irq), .iir(iir)
  );

  // {wlen[1:0], par_en, par_odd, stop2, data[7:0]}
  localparam logic [12:0] VEC [6] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 8'hA5},
    {2'd0, 1'b1, 1'b0, 1'b0, 8'h13},
    {2'd2, 1'b1, 1'b1, 1'b1, 8'h5A},
    {2'd1, 1'b0, 1'b0, 1'b1, 8'hFF},
    {2'd3, 1'b1, 1'b1, 1'b0, 8'h00},
    {2'd3, 1'b1, 1'b0, 1'b1, 8'h81}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; iir_rd = 1'b0; baud_tick = 1'b0;
    cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_stop2 = 1'b0;
    ien_thre = 1'b0; ien_temt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk);
    iir_rd = 1'b1;
    @(negedge clk);
    iir_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state
    chk("R9 txd", txd, 1);
    chk("R9 thre", thre, 1);
    chk("R9 temt", temt, 1);
    chk("R9 wr_ready", wr_ready, 1);
    chk("R9 overflow", overflow, 0);
    chk("R9 irq", irq, 0);
    chk("R9 iir", iir, 4'b0001);

    // Table: single character per format, R1 frame, R2 delayed source, R5/R6/R7
    for (int v = 0; v < 6; v++) begin
      logic [11:0] ef;
      logic [7:0]  d;
      logic        p;
      int nd, n0, nb;
      @(negedge clk);
      {cfg_wlen, cfg_par_en, cfg_par_odd, cfg_stop2, d} = VEC[v];
      ien_thre = 1'b1; ien_temt = 1'b1;
      nd = 5 + int'(cfg_wlen);
      n0 = 1 + nd + int'(cfg_par_en);
      nb = n0 + 1 + int'(cfg_stop2);
      ef = '1; ef[0] = 1'b0; p = cfg_par_odd;
      for (int i = 0; i < nd; i++) begin
        ef[1+i] = d[i];
        p = p ^ d[i];
      end
      if (cfg_par_en) ef[1+nd] = p;
      wr(d);
      @(negedge clk);
      chk("R1 start bit", txd, 0);
      chk("R7 temt busy", temt, 0);
      for (int k = 1; k <= nb; k++) begin
        tick();
        if (k < nb) chk("R1 frame bit", txd, ef[k]);
        chk("R2 hold-empty delay", iir, (k < n0) ? 4'b0001 : 4'b0010);
      end
      chk("R7 temt after stop", temt, 1);
      chk("R1 idle", txd, 1);
      chk("R6 irq", irq, 1);
      rd();
      chk("R5 read leaves line-empty", iir, 4'b1110);
      rd();
      chk("R5 second read clears", iir, 4'b0001);
    end

    // R3 immediate source after queue held two
    do_reset();
    ien_thre = 1'b1;
    wr(8'h11); wr(8'h22); wr(8'h33);
    for (int k = 0; k < 20; k++) tick();
    chk("R3 before last pop", iir, 4'b0001);
    @(negedge clk);
    chk("R3 immediate hold-empty", iir, 4'b0010);
    wr(8'h44);
    chk("R4 write clears", iir, 4'b0001);

    // R4 cancel of running delay
    do_reset();
    ien_thre = 1'b1;
    wr(8'h5C);
    @(negedge clk);
    tick(); tick();
    wr(8'h6D);
    for (int k = 0; k < 8; k++) tick();
    chk("R4 delay cancelled", iir, 4'b0001);

    // R8 overflow, dropped write, drain count
    do_reset();
    for (int k = 0; k < 17; k++) wr(8'(k));
    chk("R8 ready low when full", wr_ready, 0);
    chk("R8 no overflow yet", overflow, 0);
    wr(8'hEE);
    chk("R8 overflow set", overflow, 1);
    begin
      int cnt;
      cnt = 0;
      while (!temt && cnt < 400) begin
        tick();
        cnt++;
      end
      chk("R8 dropped write not sent (ticks)", cnt, 170);
    end
    chk("R6 disabled sources hidden", irq, 0);
    @(negedge clk); ien_temt = 1'b1;
    @(negedge clk);
    chk("R6 line-empty shown", iir, 4'b1110);
    ien_thre = 1'b1;
    @(negedge clk);
    chk("R6 hold-empty outranks", iir, 4'b0010);
    chk("R8 overflow sticky", overflow, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule